// File: doc/BRIEF.md
# Complementary PWM Channel with Dead-Time Insertion

This block is one PWM channel for driving a half-bridge. A counter runs up, down or up/down on a clock-enable strobe that comes from a prescaler outside the block. The count is compared with an active compare value to form an internal line signal. The active compare and period values are shadow copies of the buffered configuration inputs. From that line the block derives two complementary gate signals. On each gate signal, the rising edge is held back by a programmable number of counter ticks. The channel also emits single-cycle pulses for compare match, overflow, underflow and end of period.

Software, or a neighbouring block, sets the mode, the swap option, the buffered compare and period values and the dead time. It then issues a reload strobe to load the shadow copies and start counting. Later changes to the buffered values wait for the next period boundary, so a running waveform never sees a half-applied period. The stop strobe freezes the count and forces the line low. The start strobe resumes counting from the frozen count. Up/down counting gives centre-aligned output. In that mode, the top and bottom events can be exchanged between the overflow and underflow outputs.

Top module: `pwm_dt_channel`

## Requirements
- R1: After reset, out_p is 0 and out_n is 1, and match_o, ovf_o, unf_o and tc_o are all 0.
- R2: With mode = 0 (up), the count steps 0,1,…,P and then wraps to 0, so one period is P+1 ticks. The wrap tick raises ovf_o and tc_o. The line is high while count < C. Here P and C are the active period and compare values.
- R3: With mode = 1 (down), a reload sets the count to P. The count then steps down to 0 and reloads P. The tick that leaves 0 raises unf_o and tc_o. The line is high while count < C.
- R4: With mode = 2 (up/down, P ≥ 1), the count runs 0→P→0, so one period is 2·P ticks. The tick that turns at P is the top event. The tick that turns at 0 is the bottom event and also raises tc_o. With swap_i = 0, the top event drives ovf_o and the bottom event drives unf_o.
- R5: With mode = 2 and swap_i = 1, the top event drives unf_o and the bottom event drives ovf_o. All other behaviour is unchanged.
- R6: match_o pulses after every counting tick on which the count equals the active compare value. This is once per period in up mode and twice per period in up/down mode when 0 < C < P.
- R7: The active compare and period take the buffered inputs only on a reload or at a period end. A period end is the wrap in up mode, the reload of P in down mode, or the bottom turn in up/down mode. A change to the buffered inputs in mid-period leaves the current period unaltered.
- R8: With dead time D > 0, out_p rises D ticks after the line rises, and out_n rises D ticks after the line falls. Both outputs fall on the first tick that sees the line change, and the two are never high together.
- R9: With D = 0, out_n is always the inverse of out_p, and out_p follows the line one clock later.
- R10: A line pulse (high or low) that lasts D ticks or fewer produces no pulse on the output it would have raised. D spans the full range 0 to 255.
- R11: The counter and the dead-time timer advance only on clock cycles with tick_i = 1. With tick_i held low, the count, the line and the outputs hold.
- R12: stop_i clears the running state and forces the line low, and it overrides reload_i and start_i. start_i resumes counting from the held count. reload_i loads the shadow values and starts counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled count enable |
| start_i | input | 1 | Resume counting strobe |
| stop_i | input | 1 | Halt strobe, forces line low |
| reload_i | input | 1 | Load shadow values and run |
| mode_i | input | 2 | 0 up, 1 down, 2 up/down (3 acts as up) |
| swap_i | input | 1 | Exchange overflow and underflow in up/down mode |
| cmp_buf_i | input | CNT_W | Buffered compare value |
| per_buf_i | input | CNT_W | Buffered period value |
| dead_time_i | input | DT_W | Dead time in ticks |
| out_p | output | 1 | True gate output |
| out_n | output | 1 | Complementary gate output |
| match_o | output | 1 | Compare match pulse |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |
| tc_o | output | 1 | Period end pulse |

## Verification
The four event pulses appear for one clock in the cycle after the counting edge that causes them. Reload therefore counts as edge zero: with period 4, the first up-mode overflow is seen five edges later, and in up/down mode the top and bottom events are seen five and nine edges later. The line comes straight from the count register. Each gate output adds one more register stage, so with a dead time of D, out_p rises 1+D edges after the edge that raised the line. The bench drives inputs and samples outputs on the falling clock edge, counting edges from the reload strobe. Waveform shape is checked by counting high cycles over windows that span a whole number of periods, so those counts do not depend on phase.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
    typedef enum logic [1:0] {
        CNT_UP   = 2'd0,
        CNT_DOWN = 2'd1,
        CNT_UPDN = 2'd2
    } cnt_mode_e;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_dt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             reload_i,
    input  logic [1:0]       mode_i,
    input  logic             swap_i,
    input  logic [CNT_W-1:0] cmp_buf_i,
    input  logic [CNT_W-1:0] per_buf_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_act_o,
    output logic             running_o,
    output logic             match_o,
    output logic             ovf_o,
    output logic             unf_o,
    output logic             tc_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp_act;
        logic [CNT_W-1:0] per_act;
        logic             running;
        logic             dir_down;
        logic             match;
        logic             ovf;
        logic             unf;
        logic             tc;
    } ctr_state_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ctr_state_t s_d, s_q;
    cnt_mode_e  mode;
    logic       top_ev, bot_ev;

    assign mode = cnt_mode_e'(mode_i);

    always_comb begin
        s_d       = s_q;
        s_d.match = 1'b0;
        s_d.ovf   = 1'b0;
        s_d.unf   = 1'b0;
        s_d.tc    = 1'b0;
        top_ev    = 1'b0;
        bot_ev    = 1'b0;
        if (stop_i) begin
            s_d.running = 1'b0;
        end else if (reload_i) begin
            s_d.cnt      = (mode == CNT_DOWN) ? per_buf_i : '0;
            s_d.cmp_act  = cmp_buf_i;
            s_d.per_act  = per_buf_i;
            s_d.dir_down = 1'b0;
            s_d.running  = 1'b1;
        end else begin
            if (start_i) s_d.running = 1'b1;
            if (tick_i && s_q.running) begin
                s_d.match = (s_q.cnt == s_q.cmp_act);
                case (mode)
                    CNT_DOWN: begin
                        if (s_q.cnt == '0) begin
                            s_d.cnt     = per_buf_i;
                            s_d.per_act = per_buf_i;
                            s_d.cmp_act = cmp_buf_i;
                            s_d.unf     = 1'b1;
                            s_d.tc      = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt - ONE;
                        end
                    end
                    CNT_UPDN: begin
                        if (!s_q.dir_down) begin
                            if (s_q.cnt >= s_q.per_act) begin
                                s_d.dir_down = 1'b1;
                                s_d.cnt      = s_q.cnt - ONE;
                                top_ev       = 1'b1;
                            end else begin
                                s_d.cnt = s_q.cnt + ONE;
                            end
                        end else begin
                            if (s_q.cnt == '0) begin
                                s_d.dir_down = 1'b0;
                                s_d.cnt      = s_q.cnt + ONE;
                                s_d.per_act  = per_buf_i;
                                s_d.cmp_act  = cmp_buf_i;
                                s_d.tc       = 1'b1;
                                bot_ev       = 1'b1;
                            end else begin
                                s_d.cnt = s_q.cnt - ONE;
                            end
                        end
                        s_d.ovf = swap_i ? bot_ev : top_ev;
                        s_d.unf = swap_i ? top_ev : bot_ev;
                    end
                    default: begin
                        if (s_q.cnt >= s_q.per_act) begin
                            s_d.cnt     = '0;
                            s_d.per_act = per_buf_i;
                            s_d.cmp_act = cmp_buf_i;
                            s_d.ovf     = 1'b1;
                            s_d.tc      = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt + ONE;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o     = s_q.cnt;
    assign cmp_act_o = s_q.cmp_act;
    assign running_o = s_q.running;
    assign match_o   = s_q.match;
    assign ovf_o     = s_q.ovf;
    assign unf_o     = s_q.unf;
    assign tc_o      = s_q.tc;

    // R2: a running count never passes the active period (P >= 1 in up/down)
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.running |-> (s_q.cnt <= s_q.per_act));
    // R5: overflow and underflow never fire together
    assert_ovf_unf_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));
    // R7: shadow compare and period change only after a reload or at a period end
    assert_shadow_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(s_q.cmp_act) || !$stable(s_q.per_act)) |-> ($past(reload_i) || tc_o));
    // R11: without a tick (and no reload) the count holds
    assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !reload_i) |=> $stable(s_q.cnt));
endmodule

// File: rtl/pwm_line.sv
module pwm_line #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             running_i,
    output logic             line_o
);
    always_comb begin
        line_o = running_i && (cnt_i < cmp_i);
    end
endmodule

// File: rtl/pwm_deadtime.sv
module pwm_deadtime #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            line_i,
    input  logic [DT_W-1:0] dead_time_i,
    output logic            out_p,
    output logic            out_n
);
    localparam logic [DT_W-1:0] DT_ONE = DT_W'(1);

    typedef struct packed {
        logic            prev;
        logic            p;
        logic            n;
        logic [DT_W-1:0] left;
    } dt_state_t;

    dt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick_i) begin
            if (line_i != s_q.prev) begin
                s_d.prev = line_i;
                if (dead_time_i == '0) begin
                    s_d.p    = line_i;
                    s_d.n    = !line_i;
                    s_d.left = '0;
                end else begin
                    s_d.p    = 1'b0;
                    s_d.n    = 1'b0;
                    s_d.left = dead_time_i;
                end
            end else if (s_q.left != '0) begin
                s_d.left = s_q.left - DT_ONE;
                if (s_q.left == DT_ONE) begin
                    s_d.p = s_q.prev;
                    s_d.n = !s_q.prev;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.prev <= 1'b0;
            s_q.p    <= 1'b0;
            s_q.n    <= 1'b1;
            s_q.left <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_p = s_q.p;
    assign out_n = s_q.n;

    // R8: the two gate outputs are never high at once
    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_p && out_n));
    // R9: with zero dead time a seen edge leaves the outputs complementary
    assert_zero_dt_complement_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && dead_time_i == '0 && line_i != s_q.prev) |=> (out_p == !out_n));
endmodule

// File: rtl/pwm_dt_channel.sv
module pwm_dt_channel #(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             reload_i,
    input  logic [1:0]       mode_i,
    input  logic             swap_i,
    input  logic [CNT_W-1:0] cmp_buf_i,
    input  logic [CNT_W-1:0] per_buf_i,
    input  logic [DT_W-1:0]  dead_time_i,
    output logic             out_p,
    output logic             out_n,
    output logic             match_o,
    output logic             ovf_o,
    output logic             unf_o,
    output logic             tc_o
);
    logic [CNT_W-1:0] cnt, cmp_act;
    logic             running, line;

    pwm_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .reload_i  (reload_i),
        .mode_i    (mode_i),
        .swap_i    (swap_i),
        .cmp_buf_i (cmp_buf_i),
        .per_buf_i (per_buf_i),
        .cnt_o     (cnt),
        .cmp_act_o (cmp_act),
        .running_o (running),
        .match_o   (match_o),
        .ovf_o     (ovf_o),
        .unf_o     (unf_o),
        .tc_o      (tc_o)
    );

    pwm_line #(.CNT_W(CNT_W)) u_line (
        .cnt_i     (cnt),
        .cmp_i     (cmp_act),
        .running_i (running),
        .line_o    (line)
    );

    pwm_deadtime #(.DT_W(DT_W)) u_dt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .line_i      (line),
        .dead_time_i (dead_time_i),
        .out_p       (out_p),
        .out_n       (out_n)
    );
endmodule

// File: tb/pwm_dt_channel_tb.sv
module pwm_dt_channel_tb;
    localparam int CNT_W = 16;
    localparam int DT_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1, start = 1'b0, stop = 1'b0, reload = 1'b0, swap = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [CNT_W-1:0] cmp_buf = '0, per_buf = '0;
    logic [DT_W-1:0]  dead = '0;
    logic out_p, out_n, match_o, ovf_o, unf_o, tc_o;
    logic half_rate = 1'b0;

    int total = 0, bad = 0;
    int c_p, c_n, c_ovf, c_unf, c_tc, c_match, c_both, c_eq, c_tog;

    always #10 clk = ~clk;

    pwm_dt_channel #(.CNT_W(CNT_W), .DT_W(DT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start), .stop_i(stop),
        .reload_i(reload), .mode_i(mode), .swap_i(swap), .cmp_buf_i(cmp_buf),
        .per_buf_i(per_buf), .dead_time_i(dead), .out_p(out_p), .out_n(out_n),
        .match_o(match_o), .ovf_o(ovf_o), .unf_o(unf_o), .tc_o(tc_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (half_rate) tick = ~tick;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic window(input int n);
        logic last_p;
        c_p = 0; c_n = 0; c_ovf = 0; c_unf = 0; c_tc = 0;
        c_match = 0; c_both = 0; c_eq = 0; c_tog = 0;
        last_p = out_p;
        for (int i = 0; i < n; i++) begin
            step();
            c_p += int'(out_p);   c_n += int'(out_n);
            c_ovf += int'(ovf_o); c_unf += int'(unf_o);
            c_tc += int'(tc_o);   c_match += int'(match_o);
            c_both += int'(out_p && out_n);
            c_eq += int'(out_p == out_n);
            c_tog += int'(out_p != last_p);
            last_p = out_p;
        end
    endtask

    // leaves the bench just after the reload edge (edge zero)
    task automatic do_reload();
        @(negedge clk); reload = 1'b1;
        @(negedge clk); reload = 1'b0;
    endtask

    task automatic halt();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        wait_n(300);
    endtask

    task automatic setup(input int md, input int per, input int cmp, input int dt, input logic sw);
        mode = 2'(md); per_buf = CNT_W'(per); cmp_buf = CNT_W'(cmp);
        dead = DT_W'(dt); swap = sw;
    endtask

    task automatic first_events(output int k_ovf, output int k_unf, output int k_tc);
        k_ovf = -1; k_unf = -1; k_tc = -1;
        for (int i = 1; i <= 20; i++) begin
            step();
            if (k_ovf < 0 && ovf_o) k_ovf = i;
            if (k_unf < 0 && unf_o) k_unf = i;
            if (k_tc < 0 && tc_o)   k_tc = i;
        end
    endtask

    task automatic t_reset();
        check("R1 out_p", int'(out_p), 0);
        check("R1 out_n", int'(out_n), 1);
        check("R1 pulses", int'(match_o | ovf_o | unf_o | tc_o), 0);
    endtask

    task automatic t_up();
        int ko, ku, kt;
        halt(); setup(0, 4, 2, 0, 1'b0); do_reload();
        first_events(ko, ku, kt);
        check("R2 first overflow edge", ko, 5);
        check("R2 first tc edge", kt, 5);
        window(50);
        check("R2 high cycles", c_p, 20);
        check("R2 overflows", c_ovf, 10);
        check("R2 no underflow", c_unf, 0);
        check("R6 up matches", c_match, 10);
        check("R9 complement", c_eq, 0);
    endtask

    task automatic t_down();
        int ko, ku, kt;
        halt(); setup(1, 4, 2, 0, 1'b0); do_reload();
        first_events(ko, ku, kt);
        check("R3 first underflow edge", ku, 5);
        window(50);
        check("R3 high cycles", c_p, 20);
        check("R3 underflows", c_unf, 10);
        check("R3 no overflow", c_ovf, 0);
        check("R3 tc", c_tc, 10);
    endtask

    task automatic t_updn(input logic sw);
        int ko, ku, kt;
        halt(); setup(2, 4, 2, 0, sw); do_reload();
        first_events(ko, ku, kt);
        if (!sw) begin
            check("R4 top overflow edge", ko, 5);
            check("R4 bottom underflow edge", ku, 9);
            check("R4 bottom tc edge", kt, 9);
            window(40);
            check("R4 high cycles", c_p, 15);
            check("R6 centre matches", c_match, 10);
            check("R4 tc count", c_tc, 5);
        end else begin
            check("R5 top underflow edge", ku, 5);
            check("R5 bottom overflow edge", ko, 9);
        end
    endtask

    task automatic t_buffer();
        halt(); setup(0, 4, 2, 0, 1'b0); do_reload();
        cmp_buf = CNT_W'(3); per_buf = CNT_W'(9);
        wait_n(3);
        check("R7 compare held in period", int'(out_p), 0);
        wait_n(2);
        check("R7 period held in period", int'(ovf_o), 1);
        wait_n(12);
        window(50);
        check("R7 new values applied", c_p, 15);
    endtask

    task automatic t_deadtime();
        halt(); setup(0, 9, 5, 2, 1'b0); do_reload();
        wait_n(2); check("R8 p still low", int'(out_p), 0);
        wait_n(1); check("R8 p rises after D", int'(out_p), 1);
        wait_n(3); check("R8 p falls", int'(out_p), 0);
        wait_n(1); check("R8 n still low", int'(out_n), 0);
        wait_n(1); check("R8 n rises after D", int'(out_n), 1);
        window(50);
        check("R8 p width", c_p, 15);
        check("R8 n width", c_n, 15);
        check("R8 overlap", c_both, 0);
    endtask

    task automatic t_short();
        halt(); setup(0, 9, 2, 3, 1'b0); do_reload();
        wait_n(20);
        window(50);
        check("R10 short pulse suppressed", c_p, 0);
        check("R10 long side", c_n, 25);
    endtask

    task automatic t_max_dt();
        halt(); setup(0, 599, 300, 255, 1'b0); do_reload();
        wait_n(600);
        window(1200);
        check("R10 max dead time p", c_p, 90);
        check("R10 max dead time n", c_n, 90);
    endtask

    task automatic t_tick();
        halt(); setup(0, 4, 2, 0, 1'b0);
        half_rate = 1'b1;
        do_reload();
        wait_n(20);
        window(100);
        check("R11 half-rate high cycles", c_p, 40);
        check("R11 half-rate overflows", c_ovf, 10);
        half_rate = 1'b0;
        @(negedge clk); tick = 1'b0;
        window(20);
        check("R11 no tick no overflow", c_ovf, 0);
        check("R11 no tick outputs hold", c_tog, 0);
        @(negedge clk); tick = 1'b1;
    endtask

    task automatic t_stop();
        halt(); setup(0, 4, 2, 0, 1'b0); do_reload();
        wait_n(7);
        @(negedge clk); stop = 1'b1; reload = 1'b1;
        @(negedge clk); stop = 1'b0; reload = 1'b0;
        wait_n(5);
        window(30);
        check("R12 stopped p", c_p, 0);
        check("R12 stopped n", c_n, 30);
        check("R12 stopped events", c_ovf + c_tc, 0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_n(10);
        window(50);
        check("R12 resumed high cycles", c_p, 20);
    endtask

    initial begin
        fork
            begin
                wait_n(3);
                @(negedge clk); rst_n = 1'b1;
                t_reset();
                t_up();
                t_down();
                t_updn(1'b0);
                t_updn(1'b1);
                t_buffer();
                t_deadtime();
                t_short();
                t_max_dt();
                t_tick();
                t_stop();
            end
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule